// File: doc/BRIEF.md
# Refinement Search Window Calculator

This block sits between the coarse, low-resolution stage of a block-matching motion estimator and its full-resolution refinement stage. After the coarse pass, each of the four 8x8 quadrants of a macroblock has its own motion vector. The block takes those four vectors and finds the smallest and largest horizontal component and the smallest and largest vertical component. It then places a reduced refinement window over the middle of that spread.

The refinement window spans half the coarse range in each component, so it covers a quarter of the coarse area. The coarse range is [-8, 7] and the refinement window spans 8 positions. The window centre is the floor of the midpoint of the minimum and the maximum. The centre is limited so that the whole window stays inside the coarse range. The block reports the low corner of the window (its origin). The window then covers origin to origin+7 in each component.

A one-cycle strobe presents the four vectors. All results appear together on the registered outputs one clock later, with a one-cycle valid pulse.

Top module: `refine_window_calc`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid is 0 and every bound and origin output is 0.
- R2: out_valid is 1 in exactly the cycle after a cycle in which in_valid was 1 at the clock edge, and 0 in every other cycle.
- R3: out_x_min and out_x_max are the signed minimum and maximum of the four horizontal components. Component q sits in bits [5q+4:5q] of in_mv_x and is 5-bit two's complement.
- R4: out_y_min and out_y_max are the signed minimum and maximum of the four vertical components, taken from in_mv_y with the same lane layout as R3.
- R5: Whenever out_valid is 1, each minimum is less than or equal to the matching maximum, in signed order.
- R6: The window centre in each component is floor((min+max)/2), including negative odd sums (a sum of -3 gives -2). When that centre lies in [-4, 4], the origin is the centre minus 4.
- R7: A centre below -4 gives an origin of -8, and a centre above 4 gives an origin of 0. The origin therefore always lies in [-8, 0].
- R8: In a cycle where in_valid is 0, every bound and origin output keeps the value it had.
- R9: Strobes on consecutive cycles each produce their own result, one cycle after each strobe, with no mixing of lanes between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: the four vectors on the inputs are to be taken |
| in_mv_x | input | 20 | Four signed 5-bit horizontal components, quadrant q at [5q+4:5q] |
| in_mv_y | input | 20 | Four signed 5-bit vertical components, same layout |
| out_valid | output | 1 | One-cycle pulse marking fresh results |
| out_x_min | output | 5 | Signed minimum of horizontal components |
| out_x_max | output | 5 | Signed maximum of horizontal components |
| out_y_min | output | 5 | Signed minimum of vertical components |
| out_y_max | output | 5 | Signed maximum of vertical components |
| out_x_org | output | 5 | Signed horizontal origin of the refinement window |
| out_y_org | output | 5 | Signed vertical origin of the refinement window |

## Verification
Two things can happen in the same cycle: a new strobe is accepted while the result of the previous strobe is still being presented. The bench provokes this with runs of consecutive strobes, using different vectors each time. Each presented result must match the vectors of the strobe one cycle earlier, not those of the strobe being accepted. Clamping and the floor rounding of the midpoint can also act together on one result. Vectors at both extremes and with odd negative sums are chosen for this, and every output is compared against a behavioural model on every clock.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  // floor(s/2) for a signed value
  function automatic int half_floor(int s);
    return s >>> 1;
  endfunction

  // limit v into [lo, hi]
  function automatic int limit_to(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/mv_extent.sv
module mv_extent #(
  parameter int MV_W  = 5,
  parameter int NUM_Q = 4
) (
  input  logic [NUM_Q*MV_W-1:0]  lanes,
  output logic signed [MV_W-1:0] lo,
  output logic signed [MV_W-1:0] hi
);

  logic signed [MV_W-1:0] run_lo [NUM_Q];
  logic signed [MV_W-1:0] run_hi [NUM_Q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_lane
    logic signed [MV_W-1:0] lane;
    assign lane = lanes[g*MV_W +: MV_W];
    if (g == 0) begin : g_first
      assign run_lo[g] = lane;
      assign run_hi[g] = lane;
    end else begin : g_next
      assign run_lo[g] = (lane < run_lo[g-1]) ? lane : run_lo[g-1];
      assign run_hi[g] = (lane > run_hi[g-1]) ? lane : run_hi[g-1];
    end
  end

  assign lo = run_lo[NUM_Q-1];
  assign hi = run_hi[NUM_Q-1];

endmodule

// File: rtl/win_centre.sv
module win_centre
  import rwc_pkg::*;
#(
  parameter int MV_W     = 5,
  parameter int SRCH_LO  = -8,
  parameter int SRCH_HI  = 7,
  parameter int REF_SPAN = 8
) (
  input  logic signed [MV_W-1:0] lo,
  input  logic signed [MV_W-1:0] hi,
  output logic signed [MV_W-1:0] origin
);

  localparam int REF_HALF = REF_SPAN / 2;
  localparam int CTR_MIN  = SRCH_LO + REF_HALF;
  localparam int CTR_MAX  = SRCH_HI - REF_SPAN + 1 + REF_HALF;

  logic signed [MV_W:0] span_sum;
  int mid;
  int ctr;

  assign span_sum = {lo[MV_W-1], lo} + {hi[MV_W-1], hi};

  always_comb begin
    mid    = half_floor(int'(span_sum));
    ctr    = limit_to(mid, CTR_MIN, CTR_MAX);
    origin = MV_W'(ctr - REF_HALF);
  end

endmodule

// File: rtl/refine_window_calc.sv
module refine_window_calc #(
  parameter int MV_W     = 5,
  parameter int NUM_Q    = 4,
  parameter int SRCH_LO  = -8,
  parameter int SRCH_HI  = 7,
  parameter int REF_SPAN = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [NUM_Q*MV_W-1:0]     in_mv_x,
  input  logic [NUM_Q*MV_W-1:0]     in_mv_y,
  output logic                      out_valid,
  output logic signed [MV_W-1:0]    out_x_min,
  output logic signed [MV_W-1:0]    out_x_max,
  output logic signed [MV_W-1:0]    out_y_min,
  output logic signed [MV_W-1:0]    out_y_max,
  output logic signed [MV_W-1:0]    out_x_org,
  output logic signed [MV_W-1:0]    out_y_org
);

  // named event: a strobe is being captured this cycle
  logic capture;
  assign capture = in_valid;

  logic signed [MV_W-1:0] x_lo, x_hi, y_lo, y_hi;
  logic signed [MV_W-1:0] x_org_c, y_org_c;

  mv_extent #(.MV_W(MV_W), .NUM_Q(NUM_Q)) u_ext_x (
    .lanes(in_mv_x), .lo(x_lo), .hi(x_hi)
  );

  mv_extent #(.MV_W(MV_W), .NUM_Q(NUM_Q)) u_ext_y (
    .lanes(in_mv_y), .lo(y_lo), .hi(y_hi)
  );

  win_centre #(.MV_W(MV_W), .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI),
               .REF_SPAN(REF_SPAN)) u_ctr_x (
    .lo(x_lo), .hi(x_hi), .origin(x_org_c)
  );

  win_centre #(.MV_W(MV_W), .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI),
               .REF_SPAN(REF_SPAN)) u_ctr_y (
    .lo(y_lo), .hi(y_hi), .origin(y_org_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x_min <= '0;
      out_x_max <= '0;
      out_y_min <= '0;
      out_y_max <= '0;
      out_x_org <= '0;
      out_y_org <= '0;
    end else begin
      out_valid <= capture;
      if (capture) begin
        out_x_min <= x_lo;
        out_x_max <= x_hi;
        out_y_min <= y_lo;
        out_y_max <= y_hi;
        out_x_org <= x_org_c;
        out_y_org <= y_org_c;
      end
    end
  end

endmodule

// File: rtl/refine_window_calc_chk.sv
module refine_window_calc_chk #(
  parameter int MV_W     = 5,
  parameter int SRCH_LO  = -8,
  parameter int SRCH_HI  = 7,
  parameter int REF_SPAN = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   capture,
  input logic                   out_valid,
  input logic signed [MV_W-1:0] out_x_min,
  input logic signed [MV_W-1:0] out_x_max,
  input logic signed [MV_W-1:0] out_y_min,
  input logic signed [MV_W-1:0] out_y_max,
  input logic signed [MV_W-1:0] out_x_org,
  input logic signed [MV_W-1:0] out_y_org
);

  localparam logic signed [MV_W-1:0] ORG_LO = MV_W'(SRCH_LO);
  localparam logic signed [MV_W-1:0] ORG_HI = MV_W'(SRCH_HI - REF_SPAN + 1);

  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> out_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> !out_valid);

  a_r5_bounds_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x_min <= out_x_max) && (out_y_min <= out_y_max));

  a_r7_origin_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x_org >= ORG_LO) && (out_x_org <= ORG_HI) &&
                  (out_y_org >= ORG_LO) && (out_y_org <= ORG_HI));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(out_x_min) && $stable(out_x_max) &&
                 $stable(out_y_min) && $stable(out_y_max) &&
                 $stable(out_x_org) && $stable(out_y_org));

endmodule

bind refine_window_calc refine_window_calc_chk #(
  .MV_W(MV_W), .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI), .REF_SPAN(REF_SPAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .capture(capture), .out_valid(out_valid),
  .out_x_min(out_x_min), .out_x_max(out_x_max),
  .out_y_min(out_y_min), .out_y_max(out_y_max),
  .out_x_org(out_x_org), .out_y_org(out_y_org)
);

// File: tb/sim_refine_window_calc.sv
module sim_refine_window_calc;

  localparam int W = 5;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [Q*W-1:0] in_mv_x = '0;
  logic [Q*W-1:0] in_mv_y = '0;
  logic out_valid;
  logic signed [W-1:0] out_x_min, out_x_max, out_y_min, out_y_max;
  logic signed [W-1:0] out_x_org, out_y_org;

  always #2.5 clk = ~clk;

  refine_window_calc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_mv_x(in_mv_x), .in_mv_y(in_mv_y), .out_valid(out_valid),
    .out_x_min(out_x_min), .out_x_max(out_x_max),
    .out_y_min(out_y_min), .out_y_max(out_y_max),
    .out_x_org(out_x_org), .out_y_org(out_y_org)
  );

  int checks = 0;
  int failures = 0;
  bit checking = 0;
  bit done = 0;
  string cur_ctx = "idle";

  // reference model state
  bit ex_valid = 0;
  int ex_xmin = 0, ex_xmax = 0, ex_ymin = 0, ex_ymax = 0;
  int ex_xorg = 0, ex_yorg = 0;
  bit ex_xcl = 0, ex_ycl = 0;
  string ex_ctx = "reset";

  function automatic int sx(logic [W-1:0] f);
    int v = int'(f);
    if (v >= 16) v -= 32;
    return v;
  endfunction

  task automatic model(input logic [Q*W-1:0] lanes, output int mn, output int mx,
                       output int org, output bit cl);
    int c, s;
    mn = 1000; mx = -1000;
    for (int k = 0; k < Q; k++) begin
      int v = sx(lanes[k*W +: W]);
      if (v < mn) mn = v;
      if (v > mx) mx = v;
    end
    s = mn + mx;
    if (s >= 0) c = s / 2; else c = -((-s + 1) / 2);
    cl = 0;
    if (c < -4) begin c = -4; cl = 1; end
    if (c > 4)  begin c = 4;  cl = 1; end
    org = c - 4;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ex_valid = 0; ex_xmin = 0; ex_xmax = 0; ex_ymin = 0; ex_ymax = 0;
      ex_xorg = 0; ex_yorg = 0;
    end else begin
      ex_valid = in_valid;
      if (in_valid) begin
        model(in_mv_x, ex_xmin, ex_xmax, ex_xorg, ex_xcl);
        model(in_mv_y, ex_ymin, ex_ymax, ex_yorg, ex_ycl);
        ex_ctx = cur_ctx;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s [%s] actual=%0d expected=%0d", req, what, ex_ctx, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      chk("R2", "out_valid", int'(out_valid), int'(ex_valid));
      chk(ex_valid ? "R3" : "R8", "x_min", int'(out_x_min), ex_xmin);
      chk(ex_valid ? "R3" : "R8", "x_max", int'(out_x_max), ex_xmax);
      chk(ex_valid ? "R4" : "R8", "y_min", int'(out_y_min), ex_ymin);
      chk(ex_valid ? "R4" : "R8", "y_max", int'(out_y_max), ex_ymax);
      chk(!ex_valid ? "R8" : (ex_xcl ? "R7" : "R6"), "x_org", int'(out_x_org), ex_xorg);
      chk(!ex_valid ? "R8" : (ex_ycl ? "R7" : "R6"), "y_org", int'(out_y_org), ex_yorg);
      if (out_valid) begin
        chk("R5", "x_ordered", int'(out_x_min <= out_x_max), 1);
        chk("R5", "y_ordered", int'(out_y_min <= out_y_max), 1);
      end
    end
  end

  function automatic logic [Q*W-1:0] pack(int v[4]);
    logic [Q*W-1:0] r;
    for (int k = 0; k < Q; k++) r[k*W +: W] = W'(v[k]);
    return r;
  endfunction

  task automatic put(int x[4], int y[4], string c);
    @(negedge clk);
    in_mv_x = pack(x);
    in_mv_y = pack(y);
    in_valid = 1'b1;
    cur_ctx = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_mv_x = in_mv_x ^ 20'hA5A5A;
      in_mv_y = in_mv_y ^ 20'h5A5A5;
      cur_ctx = "R8 idle";
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset valid", int'(out_valid), 0);
    chk("R1", "reset x_min", int'(out_x_min), 0);
    chk("R1", "reset y_max", int'(out_y_max), 0);
    chk("R1", "reset x_org", int'(out_x_org), 0);
    chk("R1", "reset y_org", int'(out_y_org), 0);
    rst_n = 1'b1;
    checking = 1;
    idle(2);
    put('{1, -3, 4, 0}, '{2, 2, -1, 5}, "R3 R4 mixed");
    idle(2);
    put('{-3, -2, 0, 0}, '{0, -1, -2, -1}, "R6 odd negative sum");
    idle(1);
    put('{-16, -16, -16, -16}, '{15, 15, 15, 15}, "R7 clamp both ends");
    idle(1);
    put('{-16, 15, 0, 3}, '{-9, -12, -10, -11}, "R7 wide spread");
    idle(3);
    put('{0, 0, 0, 0}, '{0, 0, 0, 0}, "R9 back-to-back a");
    put('{7, -8, 2, 2}, '{-5, 3, 3, 1}, "R9 back-to-back b");
    put('{-1, -1, -1, -1}, '{9, 8, 10, 11}, "R9 back-to-back c");
    put('{5, 4, 3, 6}, '{-7, -6, -6, -8}, "R9 back-to-back d");
    idle(4);
    for (int n = 0; n < 400; n++) begin
      int xr[4], yr[4];
      for (int k = 0; k < 4; k++) begin
        xr[k] = int'($urandom_range(31)) - 16;
        yr[k] = int'($urandom_range(31)) - 16;
      end
      if ($urandom_range(3) == 0) idle(1);
      else put(xr, yr, "R9 random stream");
    end
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule